// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block collects interrupt requests from eight lines and presents them one at a time to a processor. A rising edge on a line sets that line's pending bit. A mask register keeps chosen lines out of arbitration. Among the unmasked pending lines, a priority resolver picks the winner. The output `intReq` is raised only when that winner ranks above every line already being serviced, so a higher-priority line can nest inside a lower one but not the reverse.

The processor acknowledges with two pulses on `ackPulse`. On the first pulse the winner moves from pending into service. On the second pulse an 8-bit vector appears on `vecOut`, built from a programmable 5-bit base in the upper bits and the 3-bit line number in the lower bits. A small write port loads the mask, selects the vector base and priority scheme, and issues end-of-service commands. Priority is either fixed, with line 0 highest, or rotating, where the line just released drops to the bottom of the order.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, no line is pending, masked or in service. `intReq` and `vecValid` are low, priority is fixed, and the vector base is 0.
- R2: A rising edge on `irqIn[n]` sets pending bit n in the next cycle. A line held high does not request again after it has been acknowledged. A rising edge in the same cycle as the first acknowledge pulse that takes that line leaves the line pending again.
- R3: A write with `cfgAddr`=0 loads the mask from `cfgData`, where bit n=1 blocks line n. A masked pending line never raises `intReq`. Clearing its mask bit lets the held request raise `intReq`.
- R4: In fixed priority, line 0 ranks highest and line 7 lowest.
- R5: `intReq` is high exactly when an unmasked pending line ranks strictly above every line in service. A lower or equal pending line waits, and a higher one raises `intReq`.
- R6: The first acknowledge pulse, taken while `intReq` is high, puts the winning line in service and clears its pending bit.
- R7: The second acknowledge pulse makes `vecOut` = {base[4:0], line[2:0]}, with `vecValid` high for exactly the following cycle. A first pulse taken while `intReq` is low reports line 7 and changes no state.
- R8: A write with `cfgAddr`=2 ends service of the highest-ranked line in service, under the current priority order.
- R9: A write with `cfgAddr`=1 loads the base from `cfgData[4:0]` and rotating mode from `cfgData[7]`, and resets the order to fixed-start. In rotating mode each end-of-service makes the released line the lowest in the order, and the next line up becomes the highest.
- R10: An end-of-service write and a first acknowledge pulse in the same cycle both take effect. The end-of-service command acts on the lines in service before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Request lines, edge sensitive |
| ackPulse | input | 1 | One-cycle acknowledge pulse; the pulses alternate between first and second |
| cfgWe | input | 1 | Write strobe for the command port |
| cfgAddr | input | 2 | 0 mask, 1 mode/base, 2 end-of-service, 3 unused |
| cfgData | input | 8 | Write data |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector from the last second acknowledge |
| vecValid | output | 1 | High for the cycle after a second acknowledge |

## Verification
Two pairs of events are made to fall in one cycle. The first pair is an end-of-service write issued in the same cycle as a first acknowledge. The bench then checks that the line released was the one in service before the acknowledge: a blocked lower line must raise `intReq` only after a second end-of-service. The second pair is a rising edge on a line in the same cycle as the first acknowledge that takes that line. Here the bench checks that `intReq` comes back once service of that line ends. Vectors are predicted from the base and the expected line, and compared by a scoreboard as `vecValid` appears.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef struct packed {
    logic firstAck;
    logic secondAck;
    logic maskWr;
    logic modeWr;
    logic eoiCmd;
  } strobe_t;

  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_MODE = 2'd1,
    ADDR_EOI  = 2'd2,
    ADDR_NONE = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/irq_prio_seq.sv
module irq_prio_seq
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackPulse,
  input  logic       cfgWe,
  input  logic [1:0] cfgAddr,
  output strobe_t    strb
);
  logic ackPhase;

  always_ff @(posedge clk) begin
    if (!rstN) ackPhase <= 1'b0;
    else if (ackPulse) ackPhase <= ~ackPhase;
  end

  always_comb begin
    strb.firstAck  = ackPulse & ~ackPhase;
    strb.secondAck = ackPulse & ackPhase;
    strb.maskWr    = cfgWe && (cfgAddr == ADDR_MASK);
    strb.modeWr    = cfgWe && (cfgAddr == ADDR_MODE);
    strb.eoiCmd    = cfgWe && (cfgAddr == ADDR_EOI);
  end

  // R7: acknowledge pulses alternate between first and second
  assert_phase_toggles_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse |=> (ackPhase != $past(ackPhase)));
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int BASE_W = 5,
  localparam int IDX_W = $clog2(LINES),
  localparam int VEC_W = BASE_W + IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic [LINES-1:0] cfgData,
  input  strobe_t          strb,
  output logic             intReq,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid
);
  logic [LINES-1:0]  irqPrev, irr, isr, imr;
  logic [BASE_W-1:0] vecBase;
  logic              rotEn;
  logic [IDX_W-1:0]  lowPrio, vecIdx, hiLine;
  logic [LINES-1:0]  edgeSet, pending, ackMask, eoiMask;
  logic              winFound, topFound, grant;
  logic [IDX_W-1:0]  winIdx, winRank, topIdx, topRank;

  assign edgeSet = irqIn & ~irqPrev;
  assign pending = irr & ~imr;
  assign hiLine  = (rotEn ? lowPrio : IDX_W'(LINES - 1)) + IDX_W'(1);

  // rank scan starting at the current highest-priority line
  always_comb begin
    winFound = 1'b0; winIdx = '0; winRank = '0;
    topFound = 1'b0; topIdx = '0; topRank = '0;
    for (int k = 0; k < LINES; k++) begin
      if (!winFound && pending[hiLine + IDX_W'(k)]) begin
        winFound = 1'b1;
        winIdx   = hiLine + IDX_W'(k);
        winRank  = IDX_W'(k);
      end
      if (!topFound && isr[hiLine + IDX_W'(k)]) begin
        topFound = 1'b1;
        topIdx   = hiLine + IDX_W'(k);
        topRank  = IDX_W'(k);
      end
    end
  end

  assign intReq  = winFound && (!topFound || (winRank < topRank));
  assign grant   = strb.firstAck && intReq;
  assign ackMask = grant ? (LINES'(1) << winIdx) : '0;
  assign eoiMask = (strb.eoiCmd && topFound) ? (LINES'(1) << topIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPrev  <= '0;
      irr      <= '0;
      isr      <= '0;
      imr      <= '0;
      vecBase  <= '0;
      rotEn    <= 1'b0;
      lowPrio  <= IDX_W'(LINES - 1);
      vecIdx   <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      irqPrev <= irqIn;
      irr     <= (irr & ~ackMask) | edgeSet;
      isr     <= (isr & ~eoiMask) | ackMask;
      if (strb.maskWr) imr <= cfgData;
      if (strb.modeWr) begin
        vecBase <= cfgData[BASE_W-1:0];
        rotEn   <= cfgData[LINES-1];
        lowPrio <= IDX_W'(LINES - 1);
      end else if (strb.eoiCmd && topFound && rotEn) begin
        lowPrio <= topIdx;
      end
      if (strb.firstAck) vecIdx <= grant ? winIdx : IDX_W'(LINES - 1);
      vecValid <= strb.secondAck;
      if (strb.secondAck) vecOut <= {vecBase, vecIdx};
    end
  end

  assert_edge_captured_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeSet) |=> ((irr & $past(edgeSet)) == $past(edgeSet)));

  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> !imr[winIdx]);

  assert_grant_in_service_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.firstAck && intReq) |=> isr[$past(winIdx)]);

  assert_vec_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  assert_eoi_drops_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiCmd && !strb.firstAck && (isr != '0))
      |=> (($countones(isr) + 1) == $past($countones(isr))));
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int BASE_W = 5,
  localparam int VEC_W = BASE_W + $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic             ackPulse,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [LINES-1:0] cfgData,
  output logic             intReq,
  output logic [VEC_W-1:0] vecOut,
  output logic             vecValid
);
  strobe_t strb;

  irq_prio_seq uSeq (
    .clk(clk), .rstN(rstN), .ackPulse(ackPulse),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .strb(strb)
  );

  irq_prio_dp #(.LINES(LINES), .BASE_W(BASE_W)) uDp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cfgData(cfgData), .strb(strb),
    .intReq(intReq), .vecOut(vecOut), .vecValid(vecValid)
  );
endmodule

// File: tb/tb_irq_prio_unit.sv
`timescale 1ns/1ps
module tb_irq_prio_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       ackPulse = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       intReq;
  logic [7:0] vecOut;
  logic       vecValid;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;
  logic [4:0] curBase = '0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  irq_prio_unit dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackPulse(ackPulse),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .intReq(intReq), .vecOut(vecOut), .vecValid(vecValid)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && vecValid) begin
      nChk++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R7 unexpected vector actual=%02h expected=none", vecOut);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (vecOut !== e) begin
          nFail++;
          $display("FAIL R7 vector actual=%02h expected=%02h", vecOut, e);
        end
      end
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk); cfgWe = 1'b0;
    if (a == 2'd1) curBase = d[4:0];
  endtask

  task automatic eoi();
    wrReg(2'd2, 8'h00);
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irqIn = irqIn | m;
    @(negedge clk); irqIn = irqIn & ~m;
  endtask

  task automatic ackSeq(input logic [2:0] idx);
    @(negedge clk); ackPulse = 1'b1;
    @(negedge clk); ackPulse = 1'b0;
    @(negedge clk); ackPulse = 1'b1; expQ.push_back({curBase, idx});
    @(negedge clk); ackPulse = 1'b0;
  endtask

  task automatic checkInt(input logic exp, input string tag);
    nChk++;
    if (intReq !== exp) begin
      nFail++;
      $display("FAIL %s intReq actual=%b expected=%b", tag, intReq, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkInt(1'b0, "R1");
    nChk++;
    if (vecValid !== 1'b0) begin
      nFail++;
      $display("FAIL R1 vecValid actual=%b expected=0", vecValid);
    end
    // R1 base 0, R2 edge, R6, R7
    pulse(8'h04);
    checkInt(1'b1, "R2");
    ackSeq(3'd2);
    checkInt(1'b0, "R6");
    eoi();
    checkInt(1'b0, "R6");
    // R4 fixed priority, R5 blocking, R8
    wrReg(2'd1, 8'h0A);
    pulse(8'h42);
    ackSeq(3'd1);
    checkInt(1'b0, "R5");
    eoi();
    checkInt(1'b1, "R8");
    ackSeq(3'd6);
    eoi();
    checkInt(1'b0, "R8");
    // R5 nesting, R8 highest first
    pulse(8'h10);
    ackSeq(3'd4);
    pulse(8'h01);
    checkInt(1'b1, "R5");
    ackSeq(3'd0);
    eoi();
    checkInt(1'b0, "R8");
    pulse(8'h40);
    checkInt(1'b0, "R5");
    eoi();
    checkInt(1'b1, "R8");
    ackSeq(3'd6);
    eoi();
    // R3 mask
    wrReg(2'd0, 8'h08);
    pulse(8'h08);
    checkInt(1'b0, "R3");
    wrReg(2'd0, 8'h00);
    checkInt(1'b1, "R3");
    ackSeq(3'd3);
    eoi();
    // R2 held level does not retrigger
    @(negedge clk); irqIn[5] = 1'b1;
    @(negedge clk);
    checkInt(1'b1, "R2");
    ackSeq(3'd5);
    eoi();
    repeat (2) @(negedge clk);
    checkInt(1'b0, "R2");
    irqIn[5] = 1'b0;
    // R7 spurious acknowledge
    ackSeq(3'd7);
    pulse(8'h40);
    checkInt(1'b1, "R7");
    ackSeq(3'd6);
    eoi();
    checkInt(1'b0, "R7");
    // R9 rotating priority
    wrReg(2'd1, 8'h8A);
    pulse(8'h04);
    ackSeq(3'd2);
    eoi();
    pulse(8'h12);
    ackSeq(3'd4);
    checkInt(1'b0, "R9");
    eoi();
    checkInt(1'b1, "R9");
    ackSeq(3'd1);
    eoi();
    pulse(8'h05);
    ackSeq(3'd2);
    eoi();
    ackSeq(3'd0);
    eoi();
    wrReg(2'd1, 8'h0A);
    pulse(8'h81);
    ackSeq(3'd0);
    eoi();
    ackSeq(3'd7);
    eoi();
    checkInt(1'b0, "R9");
    // R10 end-of-service together with first acknowledge
    pulse(8'h20);
    ackSeq(3'd5);
    pulse(8'h48);
    checkInt(1'b1, "R10");
    @(negedge clk); ackPulse = 1'b1; cfgWe = 1'b1; cfgAddr = 2'd2;
    @(negedge clk); ackPulse = 1'b0; cfgWe = 1'b0;
    @(negedge clk); ackPulse = 1'b1; expQ.push_back({curBase, 3'd3});
    @(negedge clk); ackPulse = 1'b0;
    checkInt(1'b0, "R10");
    eoi();
    checkInt(1'b1, "R10");
    ackSeq(3'd6);
    eoi();
    // R2 edge in the same cycle as the first acknowledge re-arms
    pulse(8'h10);
    @(negedge clk); ackPulse = 1'b1; irqIn[4] = 1'b1;
    @(negedge clk); ackPulse = 1'b0; irqIn[4] = 1'b0;
    @(negedge clk); ackPulse = 1'b1; expQ.push_back({curBase, 3'd4});
    @(negedge clk); ackPulse = 1'b0;
    checkInt(1'b0, "R2");
    eoi();
    checkInt(1'b1, "R2");
    ackSeq(3'd4);
    eoi();
    checkInt(1'b0, "R2");
    repeat (3) @(negedge clk);
    nChk++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL R7 missing vectors actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule